// File: doc/BRIEF.md
# MDIO PHY Auto-Configuration Poller

This block is a management-bus master for a bank of Ethernet PHYs. It generates the MDC clock and drives or samples the MDIO line using clause-22 style frames. Each frame has 32 preamble ones, a start code, an opcode, a PHY address, a register address, a turnaround and 16 data bits. Once reset is released, it configures each PHY in a fixed address window, lowest address first. For each PHY it writes the ability word from the `adv_ability` input into the advertisement register. It then restarts auto-negotiation with a read-modify-write of the control register.

After the last PHY is configured, the block polls without end. For every PHY in turn it reads the status register and then the link-partner ability register. It resolves link, speed, duplex and pause, and stores the result in a 4-bit field of `port_status`, one field per PHY.

The active-low `rst_n` releases both bus pins. An external controller can then use the same wires to reach the PHYs while the block is held in reset. Output enables are separate ports (`mdc_oe`, `mdio_oe`), so a pad ring or testbench builds the open bus from them.

Top module: `mdio_autocfg`

## Requirements
- R1: While `rst_n` is 0, `mdc_oe` and `mdio_oe` are both 0 (both pins float) and `port_status` is all zeros. While `rst_n` is 1, `mdc_oe` is 1.
- R2: Every frame is 64 MDC periods, sent MSB first, with fields in this order:
  - 32 ones;
  - start code 01;
  - opcode: 10 for a read, 01 for a write;
  - 5-bit PHY address;
  - 5-bit register address;
  - 2 turnaround bits;
  - 16 data bits.
- R3: MDIO is changed only while MDC is low. The master samples MDIO at the rising edge of MDC. Each MDC high phase lasts exactly `MDC_HALF` clock cycles.
- R4: On a write, the turnaround is driven as 1 then 0 and `mdio_oe` stays 1 for the whole frame. On a read, `mdio_oe` is 0 from the first turnaround bit to the end of the frame.
- R5: Between frames, `mdio_oe` is 0 and MDC rests low.
- R6: After reset, PHY addresses `FIRST_PHY` to `FIRST_PHY+NUM_PHY-1` (16 to 31 by default) are visited in increasing order. Each address gets three frames:
  - a write of `adv_ability` to register 4;
  - a read of register 0;
  - a write to register 0 of the value read with bit 12 and bit 9 set.
- R7: Polling starts after the last configuration frame and never stops. Addresses are visited in increasing order and wrap from the highest back to `FIRST_PHY`. Each address gets a read of register 1 followed by a read of register 5.
- R8: The field for the PHY at `FIRST_PHY+i` is `port_status[4i+3:4i]`:
  - bit 3: link, taken from register 1 bit 2;
  - bit 2: 100 Mb/s;
  - bit 1: full duplex;
  - bit 0: pause.
- R9: Speed and duplex are resolved from c = `adv_ability` & register 5 with this priority:
  - c[8] gives 100 full;
  - c[7] gives 100 half;
  - c[6] gives 10 full;
  - anything else gives 10 half.

  Pause is `adv_ability[10]` & register 5 bit 10. With link 0, bits 2..0 are 0.
- R10: A port's field changes only in the cycle after that port's register-5 read completes. Changes in PHY registers therefore appear after a later polling pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; also floats the bus pins |
| adv_ability | input | 16 | Ability word written to register 4 and used for resolution |
| mdc_o | output | 1 | Management clock value |
| mdc_oe | output | 1 | Output enable for MDC |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | Output enable for MDIO |
| mdio_i | input | 1 | Resolved MDIO line level |
| port_status | output | 4*NUM_PHY | Per-PHY link/speed/duplex/pause fields |

## Verification
Two things finish on the same `done` pulse: the register-5 read of the highest PHY address, and the wrap of the address counter back to the lowest one. That same pulse commits the status of the last port and selects the first port's status read as the next frame. The bench lets the sequence run through a full pass. It then requires three things: the last port's field matches its table value, no other field moved, and the frame that immediately follows the last port's register-5 read is a register-1 read of address 16. A reset asserted in the middle of a frame is a second collision, this time between tri-stating the pins and the frame in progress. The bench checks at the first sampling point after reset is asserted that both enables are already low.

// File: rtl/mdio_autocfg_pkg.sv
package mdio_autocfg_pkg;

    localparam logic [1:0] ST_CODE = 2'b01;
    localparam logic [1:0] OP_READ = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] TA_WRITE = 2'b10;

    localparam logic [4:0] REG_CTRL = 5'd0;
    localparam logic [4:0] REG_STAT = 5'd1;
    localparam logic [4:0] REG_ADV = 5'd4;
    localparam logic [4:0] REG_LPA = 5'd5;

    localparam int CTRL_AN_EN_BIT = 12;
    localparam int CTRL_AN_RST_BIT = 9;
    localparam int STAT_LINK_BIT = 2;
    localparam int AB_100FD_BIT = 8;
    localparam int AB_100HD_BIT = 7;
    localparam int AB_10FD_BIT = 6;
    localparam int AB_PAUSE_BIT = 10;

    typedef struct packed {
        logic       rd;
        logic [4:0] phy;
        logic [4:0] regad;
        logic [15:0] wdata;
    } mdio_req_t;

    typedef struct packed {
        logic link;
        logic spd100;
        logic fdx;
        logic pause;
    } port_stat_t;

    typedef enum logic [2:0] {
        PH_ADV_WR,
        PH_CTL_RD,
        PH_CTL_WR,
        PH_STS_RD,
        PH_LPA_RD
    } seq_phase_e;

    function automatic port_stat_t resolve_port(input logic up,
                                                input logic [15:0] adv,
                                                input logic [15:0] lpa);
        logic [15:0] common;
        port_stat_t  r;
        common = adv & lpa;
        r = '0;
        r.link = up;
        if (up) begin
            if (common[AB_100FD_BIT]) begin
                r.spd100 = 1'b1;
                r.fdx    = 1'b1;
            end else if (common[AB_100HD_BIT]) begin
                r.spd100 = 1'b1;
            end else if (common[AB_10FD_BIT]) begin
                r.fdx = 1'b1;
            end
            r.pause = common[AB_PAUSE_BIT];
        end
        return r;
    endfunction

endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_autocfg_pkg::*;
#(
    parameter int MDC_HALF = 20,
    parameter int PRE_LEN  = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  mdio_req_t   req,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_drive,
    input  logic        mdio_in
);
    localparam int FRAME_W  = PRE_LEN + 32;
    localparam int TA_IDX   = PRE_LEN + 14;
    localparam int DATA_IDX = PRE_LEN + 16;
    localparam int CNT_W    = $clog2(MDC_HALF + 1);
    localparam int BIT_W    = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] shreg;
    logic [BIT_W-1:0]   bit_idx;
    logic [CNT_W-1:0]   tick;
    logic               is_rd;
    logic               active;
    logic               half_done;
    logic [15:0]        load_data;
    logic [1:0]         load_op;
    logic [1:0]         load_ta;

    assign half_done = (tick == CNT_W'(MDC_HALF - 1));
    assign load_op   = req.rd ? OP_READ : OP_WRITE;
    assign load_ta   = req.rd ? 2'b11 : TA_WRITE;
    assign load_data = req.rd ? 16'h0000 : req.wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_idx <= '0;
            tick    <= '0;
            is_rd   <= 1'b0;
            active  <= 1'b0;
            done    <= 1'b0;
            mdc     <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (req_valid) begin
                    shreg   <= {{PRE_LEN{1'b1}}, ST_CODE, load_op, req.phy,
                                req.regad, load_ta, load_data};
                    bit_idx <= '0;
                    tick    <= '0;
                    is_rd   <= req.rd;
                    active  <= 1'b1;
                end
            end else if (half_done) begin
                tick <= '0;
                if (!mdc) begin
                    mdc <= 1'b1;
                    if (is_rd && (bit_idx >= BIT_W'(DATA_IDX))) begin
                        rd_data <= {rd_data[14:0], mdio_in};
                    end
                end else begin
                    mdc <= 1'b0;
                    if (bit_idx == BIT_W'(FRAME_W - 1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                    end
                end
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    assign busy       = active;
    assign mdio_out   = shreg[FRAME_W-1];
    assign mdio_drive = active && (!is_rd || (bit_idx < BIT_W'(TA_IDX)));

endmodule

// File: rtl/mdio_init_poll_seq.sv
module mdio_init_poll_seq
    import mdio_autocfg_pkg::*;
#(
    parameter int FIRST_PHY = 16,
    parameter int NUM_PHY   = 16,
    localparam int IDX_W    = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      adv_ability,
    input  logic             busy,
    input  logic             done,
    input  logic [15:0]      rd_data,
    output logic             req_valid,
    output mdio_req_t        req,
    output logic             commit,
    output logic [IDX_W-1:0] commit_idx,
    output logic             commit_link
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PHY - 1);
    localparam logic [15:0] AN_SET_MASK =
        16'((1 << CTRL_AN_EN_BIT) | (1 << CTRL_AN_RST_BIT));

    seq_phase_e       phase;
    logic [IDX_W-1:0] idx;
    logic             waiting;
    logic [15:0]      ctl_hold;
    logic             link_hold;

    assign req_valid = !waiting;

    always_comb begin
        req       = '0;
        req.phy   = 5'(FIRST_PHY + int'(idx));
        unique case (phase)
            PH_ADV_WR: begin
                req.regad = REG_ADV;
                req.wdata = adv_ability;
            end
            PH_CTL_RD: begin
                req.rd    = 1'b1;
                req.regad = REG_CTRL;
            end
            PH_CTL_WR: begin
                req.regad = REG_CTRL;
                req.wdata = ctl_hold | AN_SET_MASK;
            end
            PH_STS_RD: begin
                req.rd    = 1'b1;
                req.regad = REG_STAT;
            end
            default: begin
                req.rd    = 1'b1;
                req.regad = REG_LPA;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_ADV_WR;
            idx       <= '0;
            waiting   <= 1'b0;
            ctl_hold  <= '0;
            link_hold <= 1'b0;
        end else begin
            if (req_valid && !busy) begin
                waiting <= 1'b1;
            end
            if (done) begin
                waiting <= 1'b0;
                unique case (phase)
                    PH_ADV_WR: phase <= PH_CTL_RD;
                    PH_CTL_RD: begin
                        ctl_hold <= rd_data;
                        phase    <= PH_CTL_WR;
                    end
                    PH_CTL_WR: begin
                        if (idx == LAST_IDX) begin
                            idx   <= '0;
                            phase <= PH_STS_RD;
                        end else begin
                            idx   <= idx + 1'b1;
                            phase <= PH_ADV_WR;
                        end
                    end
                    PH_STS_RD: begin
                        link_hold <= rd_data[STAT_LINK_BIT];
                        phase     <= PH_LPA_RD;
                    end
                    default: begin
                        idx   <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
                        phase <= PH_STS_RD;
                    end
                endcase
            end
        end
    end

    assign commit      = done && (phase == PH_LPA_RD);
    assign commit_idx  = idx;
    assign commit_link = link_hold;

endmodule

// File: rtl/mdio_port_status.sv
module mdio_port_status
    import mdio_autocfg_pkg::*;
#(
    parameter int NUM_PHY = 16,
    localparam int IDX_W  = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 commit,
    input  logic [IDX_W-1:0]     commit_idx,
    input  logic                 commit_link,
    input  logic [15:0]          adv_ability,
    input  logic [15:0]          lpa_word,
    output logic [NUM_PHY*4-1:0] status_flat
);
    port_stat_t fresh;

    assign fresh = resolve_port(commit_link, adv_ability, lpa_word);

    for (genvar p = 0; p < NUM_PHY; p++) begin : g_port
        port_stat_t stat_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q <= '0;
            end else if (commit && (commit_idx == IDX_W'(p))) begin
                stat_q <= fresh;
            end
        end
        assign status_flat[4*p +: 4] = stat_q;
    end

endmodule

// File: rtl/mdio_autocfg.sv
module mdio_autocfg
    import mdio_autocfg_pkg::*;
#(
    parameter int MDC_HALF  = 20,
    parameter int PRE_LEN   = 32,
    parameter int FIRST_PHY = 16,
    parameter int NUM_PHY   = 16,
    localparam int IDX_W    = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          adv_ability,
    output logic                 mdc_o,
    output logic                 mdc_oe,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    input  logic                 mdio_i,
    output logic [NUM_PHY*4-1:0] port_status
);
    logic             rst;
    logic             req_valid;
    mdio_req_t        req;
    logic             eng_busy;
    logic             eng_done;
    logic [15:0]      eng_rd_data;
    logic             eng_drive;
    logic             commit;
    logic [IDX_W-1:0] commit_idx;
    logic             commit_link;

    assign rst = !rst_n;

    mdio_frame_engine #(
        .MDC_HALF(MDC_HALF),
        .PRE_LEN (PRE_LEN)
    ) engine_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .busy      (eng_busy),
        .done      (eng_done),
        .rd_data   (eng_rd_data),
        .mdc       (mdc_o),
        .mdio_out  (mdio_o),
        .mdio_drive(eng_drive),
        .mdio_in   (mdio_i)
    );

    mdio_init_poll_seq #(
        .FIRST_PHY(FIRST_PHY),
        .NUM_PHY  (NUM_PHY)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .adv_ability(adv_ability),
        .busy       (eng_busy),
        .done       (eng_done),
        .rd_data    (eng_rd_data),
        .req_valid  (req_valid),
        .req        (req),
        .commit     (commit),
        .commit_idx (commit_idx),
        .commit_link(commit_link)
    );

    mdio_port_status #(
        .NUM_PHY(NUM_PHY)
    ) stat_i (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .commit_idx (commit_idx),
        .commit_link(commit_link),
        .adv_ability(adv_ability),
        .lpa_word   (eng_rd_data),
        .status_flat(port_status)
    );

    assign mdc_oe  = rst_n;
    assign mdio_oe = rst_n && eng_drive;

endmodule

// File: rtl/mdio_autocfg_chk.sv
module mdio_autocfg_chk #(
    parameter int FIRST_PHY = 16,
    parameter int NUM_PHY   = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mdc_o,
    input logic                 mdc_oe,
    input logic                 mdio_o,
    input logic                 mdio_oe,
    input logic                 eng_busy,
    input logic                 req_valid,
    input logic [4:0]           req_phy,
    input logic                 commit,
    input logic [NUM_PHY*4-1:0] port_status
);
    // R1: both pins released whenever reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_float_in_reset: assert (!mdc_oe && !mdio_oe)
                else $error("R1 pins driven during reset");
        end
    end

    // R3: no MDIO movement across an MDC high phase
    a_r3_quiet_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R5: bus released and clock low outside frames
    a_r5_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> (!mdio_oe && !mdc_o));

    // R6 / R7: requested address stays in the window
    a_r6_phy_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_phy >= 5'(FIRST_PHY)) &&
                       (req_phy <= 5'(FIRST_PHY + NUM_PHY - 1))));

    // R10: status moves only right after a register-5 completion
    a_r10_status_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(port_status) |-> $past(commit));

endmodule

bind mdio_autocfg mdio_autocfg_chk #(
    .FIRST_PHY(FIRST_PHY),
    .NUM_PHY  (NUM_PHY)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mdc_o      (mdc_o),
    .mdc_oe     (mdc_oe),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .eng_busy   (eng_busy),
    .req_valid  (req_valid),
    .req_phy    (req.phy),
    .commit     (commit),
    .port_status(port_status)
);

// File: tb/mdio_autocfg_tb_top.sv
module mdio_autocfg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int NPHY       = 16;
    localparam int FIRST      = 16;
    localparam int LOGN       = 512;

    // {reg0 init, reg1, reg5, expected field with adv 16'h05E1}
    localparam logic [51:0] VEC [NPHY] = '{
        52'h3000_0004_05E1_F, 52'h0000_0004_0081_C,
        52'h0000_0004_0041_A, 52'h1000_0004_0021_8,
        52'h0000_0000_05E1_0, 52'h0000_0004_0400_9,
        52'h0000_0004_01A1_E, 52'h0000_0004_0000_8,
        52'h2100_0006_0501_F, 52'h0000_0004_0481_D,
        52'h0000_0004_0461_B, 52'h0000_0002_0041_0,
        52'h0000_0004_00C0_C, 52'h0000_0004_0160_E,
        52'h0000_0004_0421_9, 52'h0000_0004_05E1_F
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       adv = 16'h05E1;
    logic              mdc_o, mdc_oe, mdio_o, mdio_oe;
    logic [NPHY*4-1:0] port_status;
    logic              phy_oe = 1'b0;
    logic              phy_o = 1'b1;
    wire               mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    logic [15:0] m0 [32];
    logic [15:0] m1 [32];
    logic [15:0] m4 [32];
    logic [15:0] m5 [32];

    logic [1:0]  log_op   [LOGN];
    logic [4:0]  log_addr [LOGN];
    logic [4:0]  log_reg  [LOGN];
    logic [15:0] log_data [LOGN];
    int fcnt = 0;

    int contention = 0;
    int r3_viol    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_autocfg #(
        .MDC_HALF (HALF),
        .PRE_LEN  (32),
        .FIRST_PHY(FIRST),
        .NUM_PHY  (NPHY)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_ability(adv),
        .mdc_o      (mdc_o),
        .mdc_oe     (mdc_oe),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .mdio_i     (mdio_line),
        .port_status(port_status)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_rd(input logic [4:0] a, input logic [4:0] r);
        case (r)
            5'd0: return m0[a];
            5'd1: return m1[a];
            5'd4: return m4[a];
            5'd5: return m5[a];
            default: return 16'h0000;
        endcase
    endfunction

    // PHY responder and bus monitor, sampling away from the active edge
    int          pos = 0;
    int          hi_run = 0;
    logic [63:0] fr = '0;
    logic [63:0] oe_rec = '0;
    logic        mdc_q = 1'b0;
    logic        mdio_o_q = 1'b0;
    logic [15:0] rdval = '0;

    always @(negedge clk) begin
        if (mdio_oe && phy_oe) contention++;
        if (!rst_n) begin
            pos    = 0;
            phy_oe = 1'b0;
            hi_run = 0;
        end else begin
            if (mdc_o && mdc_q && mdio_oe && (mdio_o != mdio_o_q)) r3_viol++;
            if (mdc_o) hi_run++;
            if (mdc_o && !mdc_q) begin
                hi_run = 1;
                fr[63-pos]     = mdio_line;
                oe_rec[63-pos] = mdio_oe;
                pos++;
                if (pos == 64) begin
                    pos = 0;
                    // R2: preamble, start code, opcode
                    check((fr[63:32] == 32'hFFFF_FFFF) && (fr[31:30] == 2'b01) &&
                          ((fr[29:28] == 2'b10) || (fr[29:28] == 2'b01)),
                          "R2 frame format", fr, {32'hFFFF_FFFF, 2'b01, 30'h0});
                    if (fr[29:28] == 2'b01) begin
                        // R4: write turnaround and full drive
                        check((fr[17:16] == 2'b10) && (&oe_rec),
                              "R4 write turnaround", {fr[17:16], 62'h0} | oe_rec,
                              64'hFFFF_FFFF_FFFF_FFFF);
                        if (fr[22:18] == 5'd0) m0[fr[27:23]] = fr[15:0] & 16'hFDFF;
                        if (fr[22:18] == 5'd4) m4[fr[27:23]] = fr[15:0];
                    end else begin
                        // R4: read releases from turnaround on
                        check((oe_rec[17:0] == 18'h0) && (&oe_rec[63:18]),
                              "R4 read release", oe_rec, 64'hFFFF_FFFF_FFFC_0000);
                    end
                    log_op[fcnt % LOGN]   = fr[29:28];
                    log_addr[fcnt % LOGN] = fr[27:23];
                    log_reg[fcnt % LOGN]  = fr[22:18];
                    log_data[fcnt % LOGN] = fr[15:0];
                    fcnt++;
                end
            end
            if (!mdc_o && mdc_q) begin
                // R3: high phase length
                if (hi_run != HALF) r3_viol++;
                if (pos == 46) rdval = model_rd(fr[27:23], fr[22:18]);
                if (fr[29:28] == 2'b10 && pos == 47) begin
                    phy_oe = 1'b1;
                    phy_o  = 1'b0;
                end else if (fr[29:28] == 2'b10 && pos >= 48) begin
                    phy_oe = 1'b1;
                    phy_o  = rdval[63-pos];
                end else begin
                    phy_oe = 1'b0;
                end
            end
        end
        mdc_q    = mdc_o;
        mdio_o_q = mdio_o;
    end

    task automatic wait_frames(input int n);
        while (fcnt < n) @(negedge clk);
    endtask

    task automatic check_field(input int p, input logic [3:0] exp, input string req);
        check(port_status[4*p +: 4] == exp, req, 64'(port_status[4*p +: 4]), 64'(exp));
    endtask

    initial begin
        int base;
        for (int i = 0; i < 32; i++) begin
            m0[i] = '0; m1[i] = '0; m4[i] = '0; m5[i] = '0;
        end
        for (int i = 0; i < NPHY; i++) begin
            m0[FIRST+i] = VEC[i][51:36];
            m1[FIRST+i] = VEC[i][35:20];
            m5[FIRST+i] = VEC[i][19:4];
        end
        repeat (5) @(negedge clk);
        // R1 reset state
        check(!mdc_oe && !mdio_oe, "R1 float in reset", {62'h0, mdc_oe, mdio_oe}, 64'h0);
        check(port_status == '0, "R1 status cleared", 64'(port_status), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mdc_oe == 1'b1, "R1 mdc driven", 64'(mdc_oe), 64'h1);

        // R5: gap after the first frame
        wait_frames(1);
        while (mdc_o) @(negedge clk);
        check(!mdio_oe && !mdc_o, "R5 idle released", {62'h0, mdio_oe, mdc_o}, 64'h0);

        wait_frames(81);
        // R6 configuration order
        for (int k = 0; k < NPHY; k++) begin
            check(log_op[3*k] == 2'b01 && log_reg[3*k] == 5'd4 &&
                  log_addr[3*k] == 5'(FIRST+k) && log_data[3*k] == 16'h05E1,
                  "R6 adv write", {log_op[3*k], log_addr[3*k], log_reg[3*k], log_data[3*k]},
                  {2'b01, 5'(FIRST+k), 5'd4, 16'h05E1});
            check(log_op[3*k+1] == 2'b10 && log_reg[3*k+1] == 5'd0 &&
                  log_addr[3*k+1] == 5'(FIRST+k), "R6 ctrl read",
                  {log_op[3*k+1], log_addr[3*k+1], log_reg[3*k+1]},
                  {2'b10, 5'(FIRST+k), 5'd0});
            check(log_op[3*k+2] == 2'b01 && log_reg[3*k+2] == 5'd0 &&
                  log_addr[3*k+2] == 5'(FIRST+k) &&
                  log_data[3*k+2] == (VEC[k][51:36] | 16'h1200), "R6 restart write",
                  {log_op[3*k+2], log_addr[3*k+2], log_reg[3*k+2], log_data[3*k+2]},
                  {2'b01, 5'(FIRST+k), 5'd0, VEC[k][51:36] | 16'h1200});
        end
        // R7 polling order, including the wrap after the last port
        for (int k = 0; k < NPHY; k++) begin
            check(log_op[48+2*k] == 2'b10 && log_reg[48+2*k] == 5'd1 &&
                  log_addr[48+2*k] == 5'(FIRST+k), "R7 status read",
                  {log_addr[48+2*k], log_reg[48+2*k]}, {5'(FIRST+k), 5'd1});
            check(log_op[49+2*k] == 2'b10 && log_reg[49+2*k] == 5'd5 &&
                  log_addr[49+2*k] == 5'(FIRST+k), "R7 partner read",
                  {log_addr[49+2*k], log_reg[49+2*k]}, {5'(FIRST+k), 5'd5});
        end
        check(log_reg[80] == 5'd1 && log_addr[80] == 5'(FIRST), "R7 wrap to first",
              {log_addr[80], log_reg[80]}, {5'(FIRST), 5'd1});
        // R8 / R9 status table
        for (int i = 0; i < NPHY; i++) begin
            check_field(i, VEC[i][3:0], "R8 R9 resolved field");
        end

        // R10: change PHY registers, seen after a later pass
        m5[FIRST+1] = 16'h05E1;
        m1[FIRST+4] = 16'h0004;
        check_field(1, 4'hC, "R10 unchanged before poll");
        base = fcnt;
        wait_frames(base + 34);
        check_field(1, 4'hF, "R10 new partner ability");
        check_field(4, 4'hF, "R10 link up");

        // R1: reset asserted mid-frame
        base = fcnt;
        wait_frames(base + 1);
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(!mdc_oe && !mdio_oe, "R1 float mid-frame", {62'h0, mdc_oe, mdio_oe}, 64'h0);
        repeat (4) @(negedge clk);
        check(port_status == '0, "R1 status cleared again", 64'(port_status), 64'h0);
        adv = 16'h0061;
        base = fcnt;
        rst_n = 1'b1;
        wait_frames(base + 81);
        check(log_data[base % LOGN] == 16'h0061 && log_reg[base % LOGN] == 5'd4,
              "R6 new adv word", 64'(log_data[base % LOGN]), 64'h0061);
        // R9 with reduced advertisement
        check_field(0, 4'hA, "R9 10 full chosen");
        check_field(1, 4'hA, "R9 10 full chosen");
        check_field(3, 4'h8, "R9 10 half");
        check_field(5, 4'h8, "R9 pause not advertised");

        check(contention == 0, "R4 no bus contention", 64'(contention), 64'h0);
        check(r3_viol == 0, "R3 edge discipline", 64'(r3_viol), 64'h0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule